// File: doc/BRIEF.md
# Debug Control and Breakpoint Unit

This block holds the 8-bit control register a debug host uses to halt and resume a small CPU. While the halt bit is set, the unit asks the CPU to stop fetching instructions. The CPU reports each decoded breakpoint opcode (00H) with a strobe. An enable bit decides what that opcode does. With the bit clear it is a no-operation. With the bit set the unit enters the halted state, and it can also ask the serial link to send an acknowledge byte to the host.

When the flash contents are read-protected, the host can still halt the CPU but cannot release it; only a power-on reset clears the halt bit. A separate self-clearing bit asks the reset sequencer for a full system reset. The debug unit sits outside that reset and keeps its register contents. The request is withdrawn when the sequencer reports completion.

Register layout: bit 7 halt, bit 6 breakpoint enable, bit 5 acknowledge enable, bits 4..1 reserved, bit 0 system reset.

Top module: `dbg_ctl_unit`

## Requirements
- R1: On power-on reset (`rst` high at a clock edge), every register bit reads 0, and `cpu_stall`, `ack_req` and `sys_rst_req` are all 0.
- R2: A host write with bit 7 = 1 sets the halt bit, so `cpu_stall` = 1 from the next cycle. With read protection off, a host write with bit 7 = 0 clears it and `cpu_stall` returns to 0.
- R3: While bit 6 is 0, a `brk_decoded` strobe changes no register bit and causes no stall and no acknowledge.
- R4: While bit 6 is 1, a `brk_decoded` strobe sets bit 7, and `cpu_stall` is 1 in the following cycle.
- R5: While `rd_protect` is 1, a host write with bit 7 = 0 leaves bit 7 at 1. Only a power-on reset clears it.
- R6: A breakpoint that moves bit 7 from 0 to 1 while bit 5 is 1 makes `ack_req` high for exactly one cycle. That cycle is the first one in which bit 7 reads 1, and `ack_data` carries FFH.
- R7: `ack_req` stays 0 in three cases: a host write sets bit 7, a breakpoint arrives while bit 7 is already 1, or a breakpoint arrives while bit 5 is 0.
- R8: Bits 4..1 always read 0, and host writes to them have no effect.
- R9: A host write with bit 0 = 1 raises `sys_rst_req` from the next cycle. The request holds until `rst_seq_done`, and bit 0 reads 0 in the cycle after completion. Writing bit 0 = 0 has no effect. Bits 7..5 are not changed by the system reset.
- R10: When a breakpoint that sets bit 7 and a host write that clears bit 7 come in the same cycle, bit 7 ends at 1. The other bits take the written values. The breakpoint is judged on the enable bits held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset of the debug unit |
| host_wr_en | input | 1 | Host register write strobe |
| host_wr_data | input | 8 | Host write data |
| brk_decoded | input | 1 | One-cycle strobe: breakpoint opcode decoded |
| rd_protect | input | 1 | Flash read protection active |
| rst_seq_done | input | 1 | System reset sequence finished |
| cpu_stall | output | 1 | CPU must stop fetching new instructions |
| ack_req | output | 1 | One-cycle request to send the acknowledge byte |
| ack_data | output | 8 | Acknowledge byte (FFH) |
| sys_rst_req | output | 1 | System reset request, held until completion |
| reg_rdata | output | 8 | Register readback |

## Verification
A breakpoint strobe and a host write can both land on one clock edge and compete for the halt bit. The bench drives `brk_decoded` together with a write that clears bit 7 and changes the enable bits. It then expects bit 7 to be set and the other bits to take the written values. It also expects an acknowledge pulse, because the enables held before the write allowed one.

// File: rtl/dbg_ctl_pkg.sv
package dbg_ctl_pkg;

    localparam int REG_W      = 8;
    localparam int HALT_POS   = 7;
    localparam int BRKEN_POS  = 6;
    localparam int ACKEN_POS  = 5;
    localparam int RSVD_LO    = 1;
    localparam int RSVD_HI    = 4;
    localparam int RSVD_W     = RSVD_HI - RSVD_LO + 1;
    localparam int SYSRST_POS = 0;

    typedef struct packed {
        logic              halt;
        logic              brk_en;
        logic              ack_en;
        logic [RSVD_W-1:0] rsvd;
        logic              sys_rst;
    } ctl_reg_t;

    typedef struct packed {
        logic wr;
        logic halt;
        logic brk_en;
        logic ack_en;
        logic sys_rst;
    } host_req_t;

    function automatic host_req_t decode_write(input logic wr, input logic [REG_W-1:0] d);
        host_req_t r;
        r.wr      = wr;
        r.halt    = d[HALT_POS];
        r.brk_en  = d[BRKEN_POS];
        r.ack_en  = d[ACKEN_POS];
        r.sys_rst = d[SYSRST_POS];
        return r;
    endfunction

    function automatic logic [REG_W-1:0] pack_reg(input ctl_reg_t c);
        logic [REG_W-1:0] v;
        v             = '0;
        v[HALT_POS]   = c.halt;
        v[BRKEN_POS]  = c.brk_en;
        v[ACKEN_POS]  = c.ack_en;
        v[SYSRST_POS] = c.sys_rst;
        return v;
    endfunction

endpackage

// File: rtl/dbg_cfg_reg.sv
module dbg_cfg_reg
    import dbg_ctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  host_req_t req,
    output logic      brk_en,
    output logic      ack_en
);

    always_ff @(posedge clk) begin
        if (rst) begin
            brk_en <= 1'b0;
            ack_en <= 1'b0;
        end else if (req.wr) begin
            brk_en <= req.brk_en;
            ack_en <= req.ack_en;
        end
    end

endmodule

// File: rtl/dbg_halt_ctl.sv
module dbg_halt_ctl
    import dbg_ctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  host_req_t req,
    input  logic      brk_strobe,
    input  logic      brk_en,
    input  logic      ack_en,
    input  logic      rd_protect,
    output logic      halt,
    output logic      ack_pulse
);

    logic brk_hit;
    logic host_set;
    logic host_clr;
    logic halt_nxt;

    always_comb begin
        brk_hit  = brk_strobe && brk_en;
        host_set = req.wr && req.halt;
        host_clr = req.wr && !req.halt && !rd_protect;
        halt_nxt = halt;
        if (brk_hit || host_set)
            halt_nxt = 1'b1;
        else if (host_clr)
            halt_nxt = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            halt      <= 1'b0;
            ack_pulse <= 1'b0;
        end else begin
            halt      <= halt_nxt;
            ack_pulse <= brk_hit && ack_en && !halt;
        end
    end

endmodule

// File: rtl/dbg_sysrst_ctl.sv
module dbg_sysrst_ctl
    import dbg_ctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  host_req_t req,
    input  logic      seq_done,
    output logic      rst_req
);

    always_ff @(posedge clk) begin
        if (rst)
            rst_req <= 1'b0;
        else if (req.wr && req.sys_rst)
            rst_req <= 1'b1;
        else if (seq_done)
            rst_req <= 1'b0;
    end

endmodule

// File: rtl/dbg_ctl_unit.sv
module dbg_ctl_unit
    import dbg_ctl_pkg::*;
#(
    parameter logic [REG_W-1:0] ACK_CODE = 8'hFF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_wr_en,
    input  logic [REG_W-1:0] host_wr_data,
    input  logic             brk_decoded,
    input  logic             rd_protect,
    input  logic             rst_seq_done,
    output logic             cpu_stall,
    output logic             ack_req,
    output logic [REG_W-1:0] ack_data,
    output logic             sys_rst_req,
    output logic [REG_W-1:0] reg_rdata
);

    host_req_t req;
    ctl_reg_t  ctl;

    assign req = decode_write(host_wr_en, host_wr_data);

    dbg_cfg_reg i_cfg (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .brk_en (ctl.brk_en),
        .ack_en (ctl.ack_en)
    );

    dbg_halt_ctl i_halt (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .brk_strobe (brk_decoded),
        .brk_en     (ctl.brk_en),
        .ack_en     (ctl.ack_en),
        .rd_protect (rd_protect),
        .halt       (ctl.halt),
        .ack_pulse  (ack_req)
    );

    dbg_sysrst_ctl i_sysrst (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .seq_done (rst_seq_done),
        .rst_req  (ctl.sys_rst)
    );

    assign ctl.rsvd   = '0;
    assign cpu_stall  = ctl.halt;
    assign sys_rst_req = ctl.sys_rst;
    assign ack_data   = ACK_CODE;
    assign reg_rdata  = pack_reg(ctl);

endmodule

// File: rtl/dbg_ctl_unit_chk.sv
module dbg_ctl_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       host_wr_en,
    input logic [7:0] host_wr_data,
    input logic       brk_decoded,
    input logic       rd_protect,
    input logic       rst_seq_done,
    input logic       cpu_stall,
    input logic       ack_req,
    input logic       sys_rst_req,
    input logic [7:0] reg_rdata
);

    // R8
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst) reg_rdata[4:1] == 4'b0000);

    // R4
    brk_halt_chk: assert property (@(posedge clk) disable iff (rst)
        brk_decoded && reg_rdata[6] |=> cpu_stall);

    // R3
    brk_nop_chk: assert property (@(posedge clk) disable iff (rst)
        brk_decoded && !reg_rdata[6] && !host_wr_en && !cpu_stall |=> !cpu_stall);

    // R5
    protect_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_stall && rd_protect |=> cpu_stall);

    // R6
    ack_single_chk: assert property (@(posedge clk) disable iff (rst) ack_req |=> !ack_req);

    // R6
    ack_edge_chk: assert property (@(posedge clk) disable iff (rst)
        ack_req |-> cpu_stall && !$past(cpu_stall));

    // R7
    ack_src_chk: assert property (@(posedge clk) disable iff (rst) ack_req |-> $past(brk_decoded));

    // R9
    rst_hold_chk: assert property (@(posedge clk) disable iff (rst)
        sys_rst_req && !rst_seq_done |=> sys_rst_req);

    // R9
    rst_done_chk: assert property (@(posedge clk) disable iff (rst)
        rst_seq_done && !(host_wr_en && host_wr_data[0]) |=> !sys_rst_req);

endmodule

bind dbg_ctl_unit dbg_ctl_unit_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .host_wr_en   (host_wr_en),
    .host_wr_data (host_wr_data),
    .brk_decoded  (brk_decoded),
    .rd_protect   (rd_protect),
    .rst_seq_done (rst_seq_done),
    .cpu_stall    (cpu_stall),
    .ack_req      (ack_req),
    .sys_rst_req  (sys_rst_req),
    .reg_rdata    (reg_rdata)
);

// File: tb/test_dbg_ctl_unit.sv
module test_dbg_ctl_unit;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr_en = 1'b0;
    logic [7:0] host_wr_data = 8'h00;
    logic       brk_decoded = 1'b0;
    logic       rd_protect = 1'b0;
    logic       rst_seq_done = 1'b0;
    logic       cpu_stall;
    logic       ack_req;
    logic [7:0] ack_data;
    logic       sys_rst_req;
    logic [7:0] reg_rdata;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_ctl_unit i_dbg_ctl_unit (
        .clk          (clk),
        .rst          (rst),
        .host_wr_en   (host_wr_en),
        .host_wr_data (host_wr_data),
        .brk_decoded  (brk_decoded),
        .rd_protect   (rd_protect),
        .rst_seq_done (rst_seq_done),
        .cpu_stall    (cpu_stall),
        .ack_req      (ack_req),
        .ack_data     (ack_data),
        .sys_rst_req  (sys_rst_req),
        .reg_rdata    (reg_rdata)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic host_write(input logic [7:0] d);
        host_wr_en   = 1'b1;
        host_wr_data = d;
        cyc();
        host_wr_en   = 1'b0;
    endtask

    task automatic brk_pulse();
        brk_decoded = 1'b1;
        cyc();
        brk_decoded = 1'b0;
    endtask

    task automatic do_por();
        rst = 1'b1;
        cyc();
        cyc();
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_por();
        check("R1 rdata", reg_rdata, 8'h00);
        check("R1 stall", {7'b0, cpu_stall}, 8'h00);
        check("R1 ack", {7'b0, ack_req}, 8'h00);
        check("R1 sysrst", {7'b0, sys_rst_req}, 8'h00);
    endtask

    task automatic t_host_mode();
        host_write(8'h80);
        check("R2 halt set rdata", reg_rdata, 8'h80);
        check("R2 stall on", {7'b0, cpu_stall}, 8'h01);
        check("R7 no ack on host set", {7'b0, ack_req}, 8'h00);
        host_write(8'h00);
        check("R2 stall off", {7'b0, cpu_stall}, 8'h00);
    endtask

    task automatic t_reserved();
        host_write(8'h1E);
        check("R8 reserved only", reg_rdata, 8'h00);
        host_write(8'hFE);
        check("R8 reserved masked", reg_rdata, 8'hE0);
        host_write(8'h00);
        check("R8 cleared", reg_rdata, 8'h00);
    endtask

    task automatic t_brk_disabled();
        brk_pulse();
        check("R3 rdata", reg_rdata, 8'h00);
        check("R3 stall", {7'b0, cpu_stall}, 8'h00);
        check("R3 ack", {7'b0, ack_req}, 8'h00);
    endtask

    task automatic t_brk_ack();
        host_write(8'h60);
        brk_pulse();
        check("R4 rdata", reg_rdata, 8'hE0);
        check("R4 stall", {7'b0, cpu_stall}, 8'h01);
        check("R6 ack pulse", {7'b0, ack_req}, 8'h01);
        check("R6 ack byte", ack_data, 8'hFF);
        cyc();
        check("R6 ack one cycle", {7'b0, ack_req}, 8'h00);
        brk_pulse();
        check("R7 no ack while halted", {7'b0, ack_req}, 8'h00);
        host_write(8'h60);
        check("R2 resume", {7'b0, cpu_stall}, 8'h00);
    endtask

    task automatic t_brk_noack();
        host_write(8'h40);
        brk_pulse();
        check("R4 stall no-ack mode", {7'b0, cpu_stall}, 8'h01);
        check("R7 ack disabled", {7'b0, ack_req}, 8'h00);
        host_write(8'h00);
        check("R2 resume 2", reg_rdata, 8'h00);
    endtask

    task automatic t_protect();
        rd_protect = 1'b1;
        host_write(8'hC0);
        check("R5 halt set under protect", reg_rdata, 8'hC0);
        host_write(8'h40);
        check("R5 clear blocked", reg_rdata, 8'hC0);
        check("R5 stall held", {7'b0, cpu_stall}, 8'h01);
        do_por();
        check("R5 por clears", reg_rdata, 8'h00);
        rd_protect = 1'b0;
    endtask

    task automatic t_collision();
        host_write(8'h60);
        brk_decoded  = 1'b1;
        host_wr_en   = 1'b1;
        host_wr_data = 8'h20;
        cyc();
        brk_decoded  = 1'b0;
        host_wr_en   = 1'b0;
        check("R10 brk wins", reg_rdata, 8'hA0);
        check("R10 stall", {7'b0, cpu_stall}, 8'h01);
        check("R10 ack from old enables", {7'b0, ack_req}, 8'h01);
        host_write(8'h00);
        check("R10 cleanup", reg_rdata, 8'h00);
    endtask

    task automatic t_sysreset();
        host_write(8'hE1);
        check("R9 req up", {7'b0, sys_rst_req}, 8'h01);
        check("R9 rdata", reg_rdata, 8'hE1);
        cyc();
        cyc();
        check("R9 req held", {7'b0, sys_rst_req}, 8'h01);
        host_write(8'hE0);
        check("R9 write 0 no effect", reg_rdata, 8'hE1);
        rst_seq_done = 1'b1;
        cyc();
        rst_seq_done = 1'b0;
        check("R9 req cleared", {7'b0, sys_rst_req}, 8'h00);
        check("R9 other bits kept", reg_rdata, 8'hE0);
        check("R9 stall kept", {7'b0, cpu_stall}, 8'h01);
        host_write(8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        t_host_mode();
        t_reserved();
        t_brk_disabled();
        t_brk_ack();
        t_brk_noack();
        t_protect();
        t_collision();
        t_sysreset();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule